// File: doc/BRIEF.md
# RTC Alarm and Status Register File

This block is the register front end of a real-time clock. It keeps a 32-bit seconds count that moves forward by one on every pulse of a 1 Hz tick input. It also has two alarm slots. Each slot holds a compare value and a small interrupt configuration word. A shared status register carries one sticky flag per slot. Software reaches all six registers through a simple 32-bit register bus. Writes take effect on the clock edge, and read data is a combinational view of the register that the address selects.

A slot's flag is set in two cases. The first is a tick whose incremented count equals the slot's compare value. The second is a periodic event, when the slot has one enabled. A slot's periodic source is either every tick or every second tick. Flags stay set until software acknowledges them by writing ones at their bit positions in the status word. A write of zero to the status register changes nothing, so software can use it as a harmless dummy access before a real write. The interrupt output is raised while any flag is set whose slot has at least one interrupt source enabled.

Top module: `rtc_alarm_regs`

## Requirements
- R1: While reset is held, and directly after it, the seconds count, both compare values, both configuration words and both flags are zero, and `irq` is low.
- R2: Byte addresses select the registers as follows.
  - 0x00: status.
  - 0x04: slot 0 configuration.
  - 0x08: slot 1 configuration.
  - 0x0C: seconds count.
  - 0x10: slot 0 compare value.
  - 0x14: slot 1 compare value.
  
  A configuration register stores bits 2:0 only and reads zero above them. Any other address, including one with bits 1:0 non-zero, reads zero and ignores writes.
- R3: A write to 0x0C loads all 32 bits of the count. Otherwise a tick adds one to the count, wrapping from 0xFFFFFFFF to 0. When a count write and a tick fall in the same cycle, the written value is kept.
- R4: On a tick that advances the count, status bit n (n = 0 or 1) is set if the new count equals slot n's compare value. This happens whatever the slot's enables are.
- R5: Writing status with bit n at 1 clears flag n. Status bits written as 0 leave their flags unchanged, so a write of zero has no effect.
- R6: If a flag's set event and its acknowledge happen in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when some flag n is set and slot n's configuration has bit 0 (alarm enable) or bit 1 (periodic enable) set. A configuration of zero masks the slot completely.
- R8: With configuration bit 1 set and bit 2 set, every tick sets the slot's flag.
- R9: With configuration bit 1 set and bit 2 clear, the slot's flag is set only on every SLOW_TICKS-th tick counted since reset (the 2nd, 4th and so on with the default of 2).
- R10: Loading the count through the bus never sets a flag, even when the loaded value equals a compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse for each second |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Contents of the register that `busAddr` selects |
| irq | output | 1 | Interrupt request |

## Verification
The case hardest to reach from the ports is a collision: a tick that matches a compare value, or completes a periodic interval, in the same cycle as the acknowledge that would clear that flag. The slow periodic phase also depends on how many ticks have passed since reset, not on when the slot was configured. The stimulus deliberately issues acknowledges in the same step as matching ticks. The reference model counts every tick from reset on, so the slow phase is predicted no matter when periodic mode is switched on. A randomised phase with small data values then drives frequent matches between the count and the compare registers.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int WORD_W = 32;
  localparam int SLOTS  = 2;
  localparam int CFG_W  = 3;

  typedef enum logic [2:0] {
    SEL_STS   = 3'd0,
    SEL_CFG0  = 3'd1,
    SEL_CFG1  = 3'd2,
    SEL_TIME  = 3'd3,
    SEL_ALM0  = 3'd4,
    SEL_ALM1  = 3'd5,
    SEL_NONE  = 3'd7
  } regSel_t;

  typedef struct packed {
    logic             stsWr;
    logic             timeWr;
    logic [SLOTS-1:0] cfgWr;
    logic [SLOTS-1:0] almWr;
    regSel_t          rdSel;
  } busStrobe_t;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam int IDX_LO = 2;
  localparam int IDX_W  = 3;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic       upperZero;
  logic [IDX_W-1:0] wordIdx;
  regSel_t    sel;
  logic       wrEn;

  generate
    if (ADDR_W > IDX_HI + 1) begin : g_upper
      assign upperZero = (busAddr[ADDR_W-1:IDX_HI+1] == '0);
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign wordIdx = busAddr[IDX_HI:IDX_LO];
  assign wrEn    = busSel && busWrite;

  always_comb begin
    sel = SEL_NONE;
    if (upperZero && (busAddr[IDX_LO-1:0] == '0)) begin
      case (wordIdx)
        3'd0:    sel = SEL_STS;
        3'd1:    sel = SEL_CFG0;
        3'd2:    sel = SEL_CFG1;
        3'd3:    sel = SEL_TIME;
        3'd4:    sel = SEL_ALM0;
        3'd5:    sel = SEL_ALM1;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.stsWr    = wrEn && (sel == SEL_STS);
    strobe.timeWr   = wrEn && (sel == SEL_TIME);
    strobe.cfgWr[0] = wrEn && (sel == SEL_CFG0);
    strobe.cfgWr[1] = wrEn && (sel == SEL_CFG1);
    strobe.almWr[0] = wrEn && (sel == SEL_ALM0);
    strobe.almWr[1] = wrEn && (sel == SEL_ALM1);
    strobe.rdSel    = sel;
  end
endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int SLOW_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  busStrobe_t        strobe,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  localparam int DIV_W = (SLOW_TICKS > 2) ? $clog2(SLOW_TICKS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_TICKS - 1);

  logic [WORD_W-1:0] timeQ;
  logic [WORD_W-1:0] timeInc;
  logic [WORD_W-1:0] almQ [SLOTS];
  logic [CFG_W-1:0]  cfgQ [SLOTS];
  logic [SLOTS-1:0]  flagQ;
  logic [DIV_W-1:0]  divQ;
  logic              slowEv;
  logic [SLOTS-1:0]  matchEv, perEv, setEv, ackBit, srcEn;

  assign timeInc = timeQ + 1'b1;
  assign slowEv  = tick && (divQ == DIV_LAST);

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      assign matchEv[i] = tick && !strobe.timeWr && (timeInc == almQ[i]);
      assign perEv[i]   = tick && cfgQ[i][1] && (cfgQ[i][2] || slowEv);
      assign setEv[i]   = matchEv[i] || perEv[i];
      assign ackBit[i]  = strobe.stsWr && wdata[i];
      assign srcEn[i]   = cfgQ[i][0] || cfgQ[i][1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeQ <= '0;
      divQ  <= '0;
      flagQ <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        almQ[i] <= '0;
        cfgQ[i] <= '0;
      end
    end else begin
      if (strobe.timeWr) timeQ <= wdata;
      else if (tick)     timeQ <= timeInc;
      if (tick) divQ <= slowEv ? '0 : divQ + 1'b1;
      flagQ <= setEv | (flagQ & ~ackBit);
      for (int i = 0; i < SLOTS; i++) begin
        if (strobe.almWr[i]) almQ[i] <= wdata;
        if (strobe.cfgWr[i]) cfgQ[i] <= wdata[CFG_W-1:0];
      end
    end
  end

  assign irq = |(flagQ & srcEn);

  always_comb begin
    case (strobe.rdSel)
      SEL_STS:  rdata = {{(WORD_W-SLOTS){1'b0}}, flagQ};
      SEL_CFG0: rdata = {{(WORD_W-CFG_W){1'b0}}, cfgQ[0]};
      SEL_CFG1: rdata = {{(WORD_W-CFG_W){1'b0}}, cfgQ[1]};
      SEL_TIME: rdata = timeQ;
      SEL_ALM0: rdata = almQ[0];
      SEL_ALM1: rdata = almQ[1];
      default:  rdata = '0;
    endcase
  end

  // R2
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stsWr, strobe.timeWr, strobe.cfgWr, strobe.almWr}));

  // R3
  time_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.timeWr) |=> (timeQ == $past(timeQ) + 32'd1));

  // R3
  time_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.timeWr |=> (timeQ == $past(wdata)));

  // R5
  ack0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stsWr && wdata[0] && !tick) |=> !flagQ[0]);

  // R5
  ack1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stsWr && wdata[1] && !tick) |=> !flagQ[1]);

  // R10
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flagQ[0]) || $rose(flagQ[1])) |-> $past(tick));
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int SLOW_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);
  busStrobe_t strobe;

  rtc_alarm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  rtc_alarm_dp #(.SLOW_TICKS(SLOW_TICKS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .strobe (strobe),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .irq    (irq)
  );
endmodule

// File: tb/rtc_alarm_regs_bench.sv
`timescale 1ns/1ps
module rtc_alarm_regs_bench;
  localparam int SLOW = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  always #2 clk = ~clk;

  rtc_alarm_regs #(.ADDR_W(5), .SLOW_TICKS(SLOW)) u_rtc_alarm_regs (
    .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R1";

  bit [31:0] mTime;
  bit [31:0] mAlm [2];
  bit [2:0]  mCfg [2];
  bit [1:0]  mFlag;
  int        mDiv;

  function automatic bit [31:0] expRead(bit [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return {30'h0, mFlag};
      3'd1: return {29'h0, mCfg[0]};
      3'd2: return {29'h0, mCfg[1]};
      3'd3: return mTime;
      3'd4: return mAlm[0];
      3'd5: return mAlm[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit expIrq();
    bit r = 0;
    for (int i = 0; i < 2; i++)
      if (mFlag[i] && (mCfg[i][0] || mCfg[i][1])) r = 1;
    return r;
  endfunction

  task automatic check32(string t, logic [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic modelEdge(bit s, bit w, bit [4:0] a, bit [31:0] d, bit tk);
    bit [31:0] inc;
    bit slow, timeWr;
    bit [1:0] setv, ack;
    int idx;
    if (!rstN) begin
      mTime = 0; mAlm[0] = 0; mAlm[1] = 0; mCfg[0] = 0; mCfg[1] = 0;
      mFlag = 0; mDiv = 0;
      return;
    end
    idx = (a[1:0] == 2'b00) ? int'(a[4:2]) : 7;
    inc = mTime + 1;
    slow = tk && (mDiv == SLOW - 1);
    timeWr = s && w && idx == 3;
    for (int i = 0; i < 2; i++)
      setv[i] = (tk && !timeWr && inc == mAlm[i]) ||
                (tk && mCfg[i][1] && (mCfg[i][2] || slow));
    ack = (s && w && idx == 0) ? d[1:0] : 2'b00;
    mFlag = setv | (mFlag & ~ack);
    if (timeWr) mTime = d;
    else if (tk) mTime = inc;
    if (tk) mDiv = slow ? 0 : mDiv + 1;
    if (s && w && idx == 1) mCfg[0] = d[2:0];
    if (s && w && idx == 2) mCfg[1] = d[2:0];
    if (s && w && idx == 4) mAlm[0] = d;
    if (s && w && idx == 5) mAlm[1] = d;
  endtask

  task automatic step(bit s, bit w, bit [4:0] a, bit [31:0] d, bit tk);
    @(negedge clk);
    busSel = s; busWrite = w; busAddr = a; busWdata = d; tick = tk;
    @(posedge clk);
    modelEdge(s, w, a, d, tk);
    #1;
    check32({tag, " rdata"}, busRdata, expRead(a));
    check32("R7 irq", {31'h0, irq}, {31'h0, expIrq()});
  endtask

  task automatic wr(bit [4:0] a, bit [31:0] d, bit tk = 0);
    step(1, 1, a, d, tk);
  endtask

  task automatic rd(bit [4:0] a, bit tk = 0);
    step(1, 0, a, 32'h0, tk);
  endtask

  initial begin
    #80000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tag = "R1";
    rstN = 0;
    for (int i = 0; i < 3; i++) rd(5'h0C);
    @(negedge clk); rstN = 1;
    for (int a = 0; a < 8; a++) rd(5'(a * 4));

    // R2 map, config width, unmapped and misaligned
    tag = "R2";
    wr(5'h04, 32'hFFFF_FFF8); rd(5'h04);
    wr(5'h18, 32'hDEAD_BEEF); rd(5'h18);
    wr(5'h1C, 32'h1234_5678); rd(5'h1C);
    wr(5'h11, 32'h0000_00AA); rd(5'h10); rd(5'h11);
    wr(5'h10, 32'hCAFE_0001); rd(5'h10);
    wr(5'h14, 32'h0BAD_0002); rd(5'h14);
    wr(5'h04, 32'h0); wr(5'h10, 32'h0); wr(5'h14, 32'h0);

    // R3 load, advance, write wins over tick
    tag = "R3";
    wr(5'h0C, 32'h0000_0064); rd(5'h0C);
    rd(5'h0C, 1); rd(5'h0C, 1);
    wr(5'h0C, 32'h0000_0200, 1); rd(5'h0C);

    // R4 alarm slot 0 match with enable
    tag = "R4";
    wr(5'h0C, 32'd100); wr(5'h10, 32'd103); wr(5'h04, 32'd1);
    rd(5'h00, 1); rd(5'h00, 1); rd(5'h00, 1); rd(5'h00);

    // R5 dummy zero writes keep the flag, ack clears it
    tag = "R5";
    wr(5'h00, 32'h0); wr(5'h00, 32'h0); rd(5'h00);
    wr(5'h00, 32'h2); rd(5'h00);
    wr(5'h00, 32'h1); rd(5'h00);

    // R4 / R7 slot 1 flags with enables off, then masked by zero config
    tag = "R4";
    wr(5'h14, 32'd105); rd(5'h00, 1); rd(5'h00, 1);
    tag = "R7";
    wr(5'h08, 32'd1); rd(5'h00);
    wr(5'h08, 32'd0); rd(5'h00);
    wr(5'h08, 32'd2); rd(5'h08);
    wr(5'h08, 32'd0); wr(5'h00, 32'h3); rd(5'h00);

    // R3 / R4 wrap to zero matches compare of zero
    tag = "R4";
    wr(5'h0C, 32'hFFFF_FFFF); wr(5'h10, 32'h0);
    rd(5'h0C, 1); rd(5'h00);
    wr(5'h00, 32'h1);

    // R10 loading the count equal to a compare value sets nothing
    tag = "R10";
    wr(5'h10, 32'd777); wr(5'h0C, 32'd777); rd(5'h00);
    wr(5'h0C, 32'd776, 1); rd(5'h00);

    // R6 ack in the same cycle as a matching tick
    tag = "R6";
    wr(5'h0C, 32'd900); wr(5'h10, 32'd901);
    wr(5'h00, 32'h1, 1); rd(5'h00);
    wr(5'h00, 32'h1); rd(5'h00);

    // R8 every-tick periodic on slot 0
    tag = "R8";
    wr(5'h10, 32'h0); wr(5'h04, 32'h6);
    for (int i = 0; i < 4; i++) begin
      rd(5'h00, 1); wr(5'h00, 32'h1);
    end
    wr(5'h04, 32'h0); wr(5'h00, 32'h1);

    // R9 slow periodic on slot 1
    tag = "R9";
    wr(5'h08, 32'h2);
    for (int i = 0; i < 6; i++) begin
      rd(5'h00, 1); wr(5'h00, 32'h2);
    end
    tag = "R6";
    for (int i = 0; i < 4; i++) wr(5'h00, 32'h2, 1);
    wr(5'h08, 32'h0); wr(5'h00, 32'h3);

    // mixed traffic with small values for frequent matches
    tag = "R4";
    for (int i = 0; i < 400; i++) begin
      bit [4:0] a = 5'({$urandom_range(0, 7), 2'b00});
      bit [31:0] d = ($urandom_range(0, 3) == 0) ? 32'($urandom) : 32'($urandom_range(0, 7));
      step(1, 1'($urandom_range(0, 1)), a, d, 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule